// File: doc/BRIEF.md
# Graded Over/Under Trip Counter Bank

This block watches two measurement streams from an inverter's grid-sensing front end. One stream is a voltage magnitude that arrives once per half cycle. The other is a frequency value that arrives once per full cycle. Each new value is compared against a bank of limits, and every limit has its own tolerance, given as a number of update periods.

A severe limit acts on a single bad sample. A milder limit owns an 8-bit saturating up/down counter. The counter climbs on each violating sample of its own stream and falls on each in-range sample. Short excursions therefore decay away, while a sustained one ends in a trip.

When any limit fires, a shutdown flag is latched together with the index of the limit that fired. Both stay put until reset. In the default table, voltage is in whole volts and frequency is in tenths of a hertz.

Top module: `tripCounterBank`

## Requirements
- R1: After reset, `tripOut` is 0 and `tripCode` is 0. `tripCode` reads 0 whenever `tripOut` is 0.
- R2: A voltage sample with `vStb` high and a value strictly above 144 trips on that sample. `tripOut` is 1 and `tripCode` is 0 from the following cycle. A sample of exactly 144 does not trip.
- R3: A voltage sample strictly below 30 trips on that sample with code 4. A sample of exactly 30 does not trip.
- R4: A frequency sample with `fStb` high strictly above 630 trips with code 5. One strictly below 570 trips with code 8. The values 630 and 570 do not trip.
- R5: The counted limits trip on the Nth consecutive violating sample of their own stream and not before:
  - code 1: voltage above 132, N = 200
  - code 2: voltage below 104, N = 200
  - code 3: voltage below 60, N = 10
  - code 6: frequency above 605, N = 5
  - code 7: frequency below 595, N = 5
- R6: An in-range sample lowers its limit's count by one. After k violations and then m in-range samples (m ≤ k), exactly N−(k−m) further violations are needed to trip.
- R7: Counters are 8 bits wide and never wrap below 0. Any number of in-range samples from a zero count still leaves exactly N violations needed to trip.
- R8: Values present while their strobe is low are ignored. Voltage strobes neither raise nor lower the frequency counters.
- R9: Once set, `tripOut` and `tripCode` hold until reset, whatever samples follow. Reset clears them.
- R10: When several limits fire on the same clock edge, the lowest code is reported. This includes a voltage limit and a frequency limit firing together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| vStb | input | 1 | New voltage sample strobe, one cycle per half cycle |
| vVal | input | VW (9) | Voltage magnitude in volts |
| fStb | input | 1 | New frequency sample strobe, one cycle per full cycle |
| fVal | input | FW (10) | Frequency in 0.1 Hz units |
| tripOut | output | 1 | Latched shutdown request |
| tripCode | output | CODEW (4) | Index of the first limit that fired |

## Verification
A single sample is swept across every voltage from 0 to 200 and every frequency from 500 to 700, each after a fresh reset. This separates the fast limits from the counted ones and pins down the strict comparisons at the thresholds.

Runs of violating samples of length N−1 and N show the exact step count of each counted limit. Mixed runs of violations and in-range samples show the decrement and the zero floor. Holding values with the strobe low, and interleaving the two streams, shows that each counter moves only on its own strobe.

Coincident firings and post-trip stimulus separate the lowest-index priority from the latch's hold behaviour.

// File: rtl/tripPkg.sv
package tripPkg;
  // Update strobes handed from control to datapath; already gated by trip state.
  typedef struct packed {
    logic vUpd;
    logic fUpd;
  } updStrobe_t;
endpackage

// File: rtl/tripData.sv
module tripData
  import tripPkg::*;
#(
  parameter int VW = 9,
  parameter int FW = 10,
  parameter int NL = 9,
  parameter int THRW = 12,
  parameter int CNTW = 8,
  parameter logic [NL*THRW-1:0] LIM_THR = '0,
  parameter logic [NL*CNTW-1:0] LIM_STEPS = '0,
  parameter logic [NL-1:0] LIM_ABOVE = '0,
  parameter logic [NL-1:0] LIM_ISFREQ = '0
) (
  input  logic          clk,
  input  logic          rstN,
  input  updStrobe_t    strb,
  input  logic [VW-1:0] vVal,
  input  logic [FW-1:0] fVal,
  output logic [NL-1:0] fireVec
);
  localparam logic [CNTW-1:0] CNT_MAX = '1;

  for (genvar i = 0; i < NL; i++) begin : g_lim
    localparam logic [THRW-1:0] THR   = LIM_THR[i*THRW +: THRW];
    localparam logic [CNTW-1:0] STEPS = LIM_STEPS[i*CNTW +: CNTW];

    logic [THRW-1:0] sample;
    logic            upd;
    logic            viol;

    if (LIM_ISFREQ[i]) begin : g_f
      assign sample = THRW'(fVal);
      assign upd    = strb.fUpd;
    end else begin : g_v
      assign sample = THRW'(vVal);
      assign upd    = strb.vUpd;
    end

    if (LIM_ABOVE[i]) begin : g_hi
      assign viol = sample > THR;
    end else begin : g_lo
      assign viol = sample < THR;
    end

    if (STEPS <= 1) begin : g_fast
      assign fireVec[i] = upd & viol;
    end else begin : g_cnt
      logic [CNTW-1:0] cnt;
      logic [CNTW:0]   nextUp;

      assign nextUp     = {1'b0, cnt} + 1'b1;
      assign fireVec[i] = upd & viol & (nextUp >= {1'b0, STEPS});

      always_ff @(posedge clk) begin
        if (!rstN) begin
          cnt <= '0;
        end else if (upd) begin
          if (viol) begin
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
          end else begin
            if (cnt != '0) cnt <= cnt - 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tripCtrl.sv
module tripCtrl
  import tripPkg::*;
#(
  parameter int NL = 9,
  parameter int CODEW = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             vStb,
  input  logic             fStb,
  input  logic [NL-1:0]    fireVec,
  output updStrobe_t       strb,
  output logic             tripOut,
  output logic [CODEW-1:0] tripCode
);
  logic [CODEW-1:0] firstIdx;
  logic             anyFire;

  // Once tripped, counters are frozen by withholding the strobes.
  assign strb.vUpd = vStb & ~tripOut;
  assign strb.fUpd = fStb & ~tripOut;
  assign anyFire   = |fireVec;

  // Lowest index wins: scan downward so the last hit seen is the smallest.
  always_comb begin
    firstIdx = '0;
    for (int i = NL - 1; i >= 0; i--) begin
      if (fireVec[i]) firstIdx = CODEW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tripOut  <= 1'b0;
      tripCode <= '0;
    end else if (!tripOut && anyFire) begin
      tripOut  <= 1'b1;
      tripCode <= firstIdx;
    end
  end
endmodule

// File: rtl/tripCounterBank.sv
module tripCounterBank
  import tripPkg::*;
#(
  parameter int VW = 9,
  parameter int FW = 10,
  parameter int NL = 9,
  parameter int THRW = 12,
  parameter int CNTW = 8,
  // index 0 sits in the least significant slice
  parameter logic [NL*THRW-1:0] LIM_THR = {12'd570, 12'd595, 12'd605, 12'd630,
                                           12'd30, 12'd60, 12'd104, 12'd132, 12'd144},
  parameter logic [NL*CNTW-1:0] LIM_STEPS = {8'd1, 8'd5, 8'd5, 8'd1,
                                             8'd1, 8'd10, 8'd200, 8'd200, 8'd1},
  parameter logic [NL-1:0] LIM_ABOVE  = 9'b001100011,
  parameter logic [NL-1:0] LIM_ISFREQ = 9'b111100000,
  localparam int CODEW = $clog2(NL)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             vStb,
  input  logic [VW-1:0]    vVal,
  input  logic             fStb,
  input  logic [FW-1:0]    fVal,
  output logic             tripOut,
  output logic [CODEW-1:0] tripCode
);
  updStrobe_t    strb;
  logic [NL-1:0] fireVec;

  tripCtrl #(.NL(NL), .CODEW(CODEW)) u_ctrl (
    .clk(clk), .rstN(rstN), .vStb(vStb), .fStb(fStb), .fireVec(fireVec),
    .strb(strb), .tripOut(tripOut), .tripCode(tripCode)
  );

  tripData #(
    .VW(VW), .FW(FW), .NL(NL), .THRW(THRW), .CNTW(CNTW),
    .LIM_THR(LIM_THR), .LIM_STEPS(LIM_STEPS),
    .LIM_ABOVE(LIM_ABOVE), .LIM_ISFREQ(LIM_ISFREQ)
  ) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .vVal(vVal), .fVal(fVal),
    .fireVec(fireVec)
  );
endmodule

// File: rtl/tripCheck.sv
module tripCheck #(
  parameter int VW = 9,
  parameter int FW = 10,
  parameter int NL = 9,
  parameter int THRW = 12,
  parameter logic [NL*THRW-1:0] LIM_THR = '0,
  localparam int CODEW = $clog2(NL)
) (
  input logic             clk,
  input logic             rstN,
  input logic             vStb,
  input logic [VW-1:0]    vVal,
  input logic             fStb,
  input logic [FW-1:0]    fVal,
  input logic             tripOut,
  input logic [CODEW-1:0] tripCode
);
  // Default table: slice 0 = voltage high fast, 4 = voltage low fast, 5 = freq high fast
  localparam logic [THRW-1:0] THR_VHI = LIM_THR[0*THRW +: THRW];
  localparam logic [THRW-1:0] THR_VLO = LIM_THR[4*THRW +: THRW];
  localparam logic [THRW-1:0] THR_FHI = LIM_THR[5*THRW +: THRW];

  p_idle_code_r1: assert property (@(posedge clk) disable iff (!rstN)
    !tripOut |-> tripCode == '0);

  p_fast_vhi_r2: assert property (@(posedge clk) disable iff (!rstN)
    (vStb && !tripOut && THRW'(vVal) > THR_VHI) |=> (tripOut && tripCode == '0));

  p_fast_vlo_r3: assert property (@(posedge clk) disable iff (!rstN)
    (vStb && !tripOut && THRW'(vVal) < THR_VLO) |=> (tripOut && tripCode <= CODEW'(4)));

  p_fast_fhi_r4: assert property (@(posedge clk) disable iff (!rstN)
    (fStb && !tripOut && THRW'(fVal) > THR_FHI) |=> tripOut);

  p_strobe_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tripOut) |-> $past(vStb || fStb));

  p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    tripOut |=> (tripOut && $stable(tripCode)));
endmodule

bind tripCounterBank tripCheck #(
  .VW(VW), .FW(FW), .NL(NL), .THRW(THRW), .LIM_THR(LIM_THR)
) u_chk (.*);

// File: tb/tripCounterBank_tb.sv
module tripCounterBank_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       vStb = 1'b0;
  logic [8:0] vVal = '0;
  logic       fStb = 1'b0;
  logic [9:0] fVal = 10'd600;
  logic       tripOut;
  logic [3:0] tripCode;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tripCounterBank u_dut (
    .clk(clk), .rstN(rstN), .vStb(vStb), .vVal(vVal),
    .fStb(fStb), .fVal(fVal), .tripOut(tripOut), .tripCode(tripCode)
  );

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; vStb = 1'b0; fStb = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic vS(input int v);
    @(negedge clk);
    vVal = 9'(v); vStb = 1'b1;
    @(negedge clk);
    vStb = 1'b0;
  endtask

  task automatic fS(input int f);
    @(negedge clk);
    fVal = 10'(f); fStb = 1'b1;
    @(negedge clk);
    fStb = 1'b0;
  endtask

  task automatic bothS(input int v, input int f);
    @(negedge clk);
    vVal = 9'(v); fVal = 10'(f); vStb = 1'b1; fStb = 1'b1;
    @(negedge clk);
    vStb = 1'b0; fStb = 1'b0;
  endtask

  task automatic vRun(input int v, input int n);
    for (int k = 0; k < n; k++) vS(v);
  endtask

  task automatic fRun(input int f, input int n);
    for (int k = 0; k < n; k++) fS(f);
  endtask

  task automatic chk(input string req, input bit expT, input int expC);
    checks++;
    if (tripOut !== expT || tripCode !== 4'(expC)) begin
      failures++;
      $display("FAIL %s: trip=%0b code=%0d expected trip=%0b code=%0d",
               req, tripOut, tripCode, expT, expC);
    end
  endtask

  initial begin
    // R1 reset state
    doReset();
    @(negedge clk);
    chk("R1", 1'b0, 0);

    // R2 R3 sweep of single voltage samples
    for (int v = 0; v <= 200; v++) begin
      doReset();
      vS(v);
      if (v > 144)     chk("R2", 1'b1, 0);
      else if (v < 30) chk("R3", 1'b1, 4);
      else             chk("R2/R3 no-trip", 1'b0, 0);
    end

    // R4 sweep of single frequency samples
    for (int f = 500; f <= 700; f++) begin
      doReset();
      fS(f);
      if (f > 630)      chk("R4", 1'b1, 5);
      else if (f < 570) chk("R4", 1'b1, 8);
      else              chk("R4 no-trip", 1'b0, 0);
    end

    // R5 exact step counts
    doReset(); vRun(140, 199); chk("R5 code1 N-1", 1'b0, 0);
    vS(140); chk("R5 code1 N", 1'b1, 1);
    doReset(); vRun(100, 199); chk("R5 code2 N-1", 1'b0, 0);
    vS(100); chk("R5 code2 N", 1'b1, 2);
    doReset(); vRun(50, 9); chk("R5 code3 N-1", 1'b0, 0);
    vS(50); chk("R5 code3 N", 1'b1, 3);
    doReset(); fRun(620, 4); chk("R5 code6 N-1", 1'b0, 0);
    fS(620); chk("R5 code6 N", 1'b1, 6);
    doReset(); fRun(580, 4); chk("R5 code7 N-1", 1'b0, 0);
    fS(580); chk("R5 code7 N", 1'b1, 7);

    // R6 decrement: 6 up, 2 down -> 6 more needed for code 3
    doReset(); vRun(50, 6); vRun(100, 2); vRun(50, 5);
    chk("R6 volt before", 1'b0, 0);
    vS(50); chk("R6 volt trip", 1'b1, 3);
    // 3 up, 2 down -> 4 more needed for code 6
    doReset(); fRun(620, 3); fRun(600, 2); fRun(620, 3);
    chk("R6 freq before", 1'b0, 0);
    fS(620); chk("R6 freq trip", 1'b1, 6);

    // R7 zero floor
    doReset(); vRun(120, 20); vRun(50, 9);
    chk("R7 volt before", 1'b0, 0);
    vS(50); chk("R7 volt trip", 1'b1, 3);
    doReset(); fRun(600, 10); fRun(580, 4);
    chk("R7 freq before", 1'b0, 0);
    fS(580); chk("R7 freq trip", 1'b1, 7);

    // R8 values without strobe are ignored; voltage strobes leave freq counters alone
    doReset();
    @(negedge clk); vVal = 9'd200; fVal = 10'd700;
    repeat (5) @(negedge clk);
    chk("R8 no strobe", 1'b0, 0);
    fRun(620, 4);
    fVal = 10'd620;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); vVal = 9'd120; vStb = 1'b1;
      @(negedge clk); vStb = 1'b0;
    end
    chk("R8 cross stream", 1'b0, 0);
    fS(620); chk("R8 freq count kept", 1'b1, 6);

    // R9 latch holds, reset clears
    doReset(); vRun(50, 10); chk("R9 set", 1'b1, 3);
    vS(150); fS(700); repeat (5) @(negedge clk);
    chk("R9 hold", 1'b1, 3);
    doReset(); @(negedge clk); chk("R9 cleared", 1'b0, 0);

    // R10 priority
    doReset(); bothS(150, 650); chk("R10 volt+freq", 1'b1, 0);
    doReset(); vRun(50, 9); vS(20); chk("R10 code3 over 4", 1'b1, 3);
    doReset(); fRun(620, 4); fS(640); chk("R10 code5 over 6", 1'b1, 5);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule